// File: doc/BRIEF.md
# Bus Clock Stop Handshake Controller

This block is the host end of a shared open-drain clock-request line. It lets an idle shared bus have its clock stopped and started again. It runs on a free-running reference clock, so its counters keep advancing while the bus clock is off. It watches four activity sources:

- cycles on the primary bus
- cycles on the secondary bus
- internal requests that need the bus
- serial interrupt activity

While the bus is busy, the controller holds the request line low. Once the bus has been quiet for long enough, it drives the line high for a single clock and then lets go of it. It then watches whether any peripheral pulls the line low again. If nobody objects during a fixed window, it drives an active-low stop output to the external clock generator and reports the stopped state.

A peripheral can restart the clock by pulling the line low. An internal request can also restart it. In either case the controller releases the stop and drives the line low again.

The open-drain line is modelled as three signals: a drive enable, a drive value, and the sampled level of the line. Outside the block, an undriven line is pulled up to high.

Top module: `bus_clk_stop_ctrl`

## Requirements
- R1: Any activity input (`bus_cycle`, `sec_bus_cycle`, `int_req`, `serirq_act`) that is high in a running-state clock restarts the idle count from zero. Any such input that is high during the watch window cancels the stop, and the block returns to the running state on the next clock.
- R2: After `IDLE_CLKS` (default 29) consecutive idle clocks in the running state, the block drives the line high (`ckr_oe`=1, `ckr_out`=1) for exactly one clock. It then stops driving the line (`ckr_oe`=0).
- R3: Throughout the watch window that follows the release, `ckr_oe` is 0 and `stop_n` is 1.
- R4: If the sampled line `ckr_in` stays high, with no activity, for `WIN_CLKS` (default 6) consecutive clocks of the watch window, then on the next clock `stop_n` goes low and `clk_stopped` goes high. Before that count is reached, neither output changes.
- R5: While the clock is stopped, one clock with `ckr_in` low, or one clock with `int_req` high, moves the block back to running on the next clock: `stop_n`=1, `ckr_oe`=1, `ckr_out`=0.
- R6: If a peripheral pulls `ckr_in` low during the watch window, the block returns to driving the line low on the next clock. A full `IDLE_CLKS` idle period is then needed before the next release.
- R7: The idle count advances only on consecutive idle clocks, and it starts from zero on every entry to the running state.
- R8: While the clock is stopped, `bus_cycle`, `sec_bus_cycle` and `serirq_act` have no effect, and the block stays stopped.
- R9: Asserting `rst_n` low immediately sets `ckr_oe`=1, `ckr_out`=0, `stop_n`=1, `clk_stopped`=0 and clears both counters. The release of `rst_n` takes effect two clocks later.
- R10: `clk_stopped` is high exactly when `stop_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cycle | input | 1 | A cycle is running on the primary bus |
| sec_bus_cycle | input | 1 | A cycle is running on the secondary bus |
| int_req | input | 1 | An internal device needs the bus |
| serirq_act | input | 1 | Serial interrupt line activity |
| ckr_in | input | 1 | Sampled level of the shared request line (1 = high) |
| ckr_oe | output | 1 | Drive enable for the request line |
| ckr_out | output | 1 | Value driven on the request line when enabled |
| stop_n | output | 1 | Active-low stop request to the clock generator |
| clk_stopped | output | 1 | High while the bus clock is stopped |

## Verification
Idle stretches are run to exactly one clock short of each threshold and then to the threshold itself, which separates off-by-one errors in the idle count from off-by-one errors in the watch count. Each of the four activity sources is injected on its own, after a partial idle count. A later run that is one clock short of a full period must stay running, which shows the count restarted rather than paused. Peripheral pulls are applied once during the watch window and once after the stop: the first distinguishes the veto path, the second the restart path. Bus-side activity while stopped must leave the stop in place, whereas an internal request must end it. A reset asserted in the middle of the watch window shows that reset takes effect asynchronously.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_RELEASE = 2'd1,
    ST_WATCH   = 2'd2,
    ST_STOPPED = 2'd3
  } clkstop_state_e;
endpackage

// File: rtl/clkstop_counter.sv
module clkstop_counter #(
  parameter int LIMIT = 29
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign last = (cnt_q == W'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (en && !last)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  // R7: the count never passes its terminal value
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W'(LIMIT - 1));

  // R7: a clear always returns the count to zero
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
  import clkstop_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           activity,
  input  logic           int_req,
  input  logic           line_in,
  input  logic           idle_last,
  input  logic           win_last,
  output clkstop_state_e state_q,
  output logic           idle_clr,
  output logic           idle_en,
  output logic           win_clr,
  output logic           win_en
);
  clkstop_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (!activity && idle_last) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_WATCH;
      ST_WATCH: begin
        if (!line_in || activity) state_d = ST_RUN;
        else if (win_last)        state_d = ST_STOPPED;
      end
      ST_STOPPED: if (!line_in || int_req) state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_comb begin
    idle_en  = (state_q == ST_RUN) && !activity;
    idle_clr = (state_q != ST_RUN) || activity;
    win_en   = (state_q == ST_WATCH) && line_in && !activity;
    win_clr  = (state_q != ST_WATCH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_RUN;
    else
      state_q <= state_d;
  end

  // R6: a pull on the line during the watch window vetoes the stop
  a_r6_veto: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WATCH && !line_in) |=> (state_q == ST_RUN));

  // R1: activity during the watch window cancels the stop
  a_r1_watch_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WATCH && activity) |=> (state_q == ST_RUN));

  // R4: the stopped state is entered only from the watch window
  a_r4_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOPPED && $past(state_q) != ST_STOPPED) |-> ($past(state_q) == ST_WATCH));
endmodule

// File: rtl/bus_clk_stop_ctrl.sv
module bus_clk_stop_ctrl
  import clkstop_pkg::*;
#(
  parameter int IDLE_CLKS = 29,
  parameter int WIN_CLKS  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_cycle,
  input  logic sec_bus_cycle,
  input  logic int_req,
  input  logic serirq_act,
  input  logic ckr_in,
  output logic ckr_oe,
  output logic ckr_out,
  output logic stop_n,
  output logic clk_stopped
);
  logic [1:0]     rst_sync_q;
  logic           rst_s_n;
  logic           activity;
  logic           idle_clr;
  logic           idle_en;
  logic           idle_last;
  logic           win_clr;
  logic           win_en;
  logic           win_last;
  clkstop_state_e state_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign activity = bus_cycle | sec_bus_cycle | int_req | serirq_act;

  clkstop_counter #(.LIMIT(IDLE_CLKS)) u_idle_cnt (
    .clk  (clk),
    .rst_n(rst_s_n),
    .clr  (idle_clr),
    .en   (idle_en),
    .last (idle_last)
  );

  clkstop_counter #(.LIMIT(WIN_CLKS)) u_win_cnt (
    .clk  (clk),
    .rst_n(rst_s_n),
    .clr  (win_clr),
    .en   (win_en),
    .last (win_last)
  );

  clkstop_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .activity (activity),
    .int_req  (int_req),
    .line_in  (ckr_in),
    .idle_last(idle_last),
    .win_last (win_last),
    .state_q  (state_q),
    .idle_clr (idle_clr),
    .idle_en  (idle_en),
    .win_clr  (win_clr),
    .win_en   (win_en)
  );

  assign ckr_oe      = (state_q == ST_RUN) || (state_q == ST_RELEASE);
  assign ckr_out     = (state_q == ST_RELEASE);
  assign stop_n      = (state_q != ST_STOPPED);
  assign clk_stopped = (state_q == ST_STOPPED);

  // R2: the line is driven high for a single clock, then released
  a_r2_release_one_cycle: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ckr_oe && ckr_out) |=> !ckr_oe);

  // R10: the status output mirrors the stop output
  a_r10_status_matches: assert property (@(posedge clk) disable iff (!rst_s_n)
    clk_stopped == !stop_n);

  // R5: a low line while stopped restarts the clock and drives the line low
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_s_n)
    (clk_stopped && !ckr_in) |=> (stop_n && ckr_oe && !ckr_out));

  // R8: bus-side activity alone does not end the stop
  a_r8_stay_stopped: assert property (@(posedge clk) disable iff (!rst_s_n)
    (clk_stopped && ckr_in && !int_req) |=> clk_stopped);

  // R3: the stop is asserted only after the line was released and seen high
  a_r3_stop_after_release: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(stop_n) |-> ($past(!ckr_oe) && $past(ckr_in)));
endmodule

// File: tb/tb_bus_clk_stop_ctrl.sv
module tb_bus_clk_stop_ctrl;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [7:0] n;     // clocks to hold the inputs
    logic [3:0] act;   // {int_req, serirq_act, sec_bus_cycle, bus_cycle}
    logic       pull;  // peripheral pulls the line low
    logic [3:0] exp;   // {ckr_oe, ckr_out, stop_n, clk_stopped}
    logic [3:0] req;   // requirement number
  } vec_t;

  // expected output codes: RUN 1010, RELEASE 1110, WATCH 0010, STOPPED 0001
  localparam vec_t VEC [27] = '{
    '{8'd28, 4'h0, 1'b0, 4'b1010, 4'd2},  // R2 one clock short of release
    '{8'd1,  4'h0, 1'b0, 4'b1110, 4'd2},  // R2 release clock
    '{8'd1,  4'h0, 1'b0, 4'b0010, 4'd3},  // R3 line let go
    '{8'd5,  4'h0, 1'b0, 4'b0010, 4'd4},  // R4 one short of stop
    '{8'd1,  4'h0, 1'b0, 4'b0001, 4'd4},  // R4 stopped
    '{8'd3,  4'h1, 1'b0, 4'b0001, 4'd8},  // R8 bus cycle ignored
    '{8'd2,  4'h6, 1'b0, 4'b0001, 4'd8},  // R8 secondary bus and serirq ignored
    '{8'd1,  4'h0, 1'b1, 4'b1010, 4'd5},  // R5 peripheral restart
    '{8'd20, 4'h0, 1'b0, 4'b1010, 4'd7},  // R7 partial idle
    '{8'd1,  4'h4, 1'b0, 4'b1010, 4'd1},  // R1 serirq restarts count
    '{8'd28, 4'h0, 1'b0, 4'b1010, 4'd7},  // R7 count restarted, not paused
    '{8'd1,  4'h0, 1'b0, 4'b1110, 4'd2},  // R2
    '{8'd1,  4'h0, 1'b0, 4'b0010, 4'd3},  // R3
    '{8'd2,  4'h0, 1'b0, 4'b0010, 4'd3},  // R3
    '{8'd1,  4'h0, 1'b1, 4'b1010, 4'd6},  // R6 veto
    '{8'd28, 4'h0, 1'b0, 4'b1010, 4'd6},  // R6 full idle needed again
    '{8'd1,  4'h0, 1'b0, 4'b1110, 4'd6},  // R6
    '{8'd7,  4'h0, 1'b0, 4'b0001, 4'd4},  // R4 release to stop
    '{8'd1,  4'h8, 1'b0, 4'b1010, 4'd5},  // R5 internal restart
    '{8'd29, 4'h0, 1'b0, 4'b1110, 4'd2},  // R2
    '{8'd1,  4'h0, 1'b0, 4'b0010, 4'd3},  // R3
    '{8'd1,  4'h2, 1'b0, 4'b1010, 4'd1},  // R1 activity cancels in watch
    '{8'd28, 4'h0, 1'b0, 4'b1010, 4'd1},  // R1
    '{8'd1,  4'h1, 1'b0, 4'b1010, 4'd1},  // R1 bus cycle restarts count
    '{8'd28, 4'h0, 1'b0, 4'b1010, 4'd1},  // R1
    '{8'd1,  4'h8, 1'b0, 4'b1010, 4'd1},  // R1 internal request restarts count
    '{8'd29, 4'h0, 1'b0, 4'b1110, 4'd2}   // R2
  };

  logic clk;
  logic rst_n;
  logic bus_cycle, sec_bus_cycle, int_req, serirq_act;
  logic pull;
  logic ckr_in, ckr_oe, ckr_out, stop_n, clk_stopped;
  int   n_checks;
  int   n_fail;
  bit   done;

  // open-drain line with pull-up
  assign ckr_in = ckr_oe ? ckr_out : !pull;

  bus_clk_stop_ctrl dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_cycle    (bus_cycle),
    .sec_bus_cycle(sec_bus_cycle),
    .int_req      (int_req),
    .serirq_act   (serirq_act),
    .ckr_in       (ckr_in),
    .ckr_oe       (ckr_oe),
    .ckr_out      (ckr_out),
    .stop_n       (stop_n),
    .clk_stopped  (clk_stopped)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic [3:0] exp, input int req);
    logic [3:0] act;
    act = {ckr_oe, ckr_out, stop_n, clk_stopped};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: outputs {oe,out,stop_n,stopped} = %b, expected %b", req, act, exp);
    end
  endtask

  task automatic set_act(input logic [3:0] a);
    {int_req, serirq_act, sec_bus_cycle, bus_cycle} = a;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    pull     = 1'b0;
    rst_n    = 1'b0;
    set_act(4'h1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(4'b1010, 9);  // R9 reset state
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(4'b1010, 9);  // R9 still running after release

    for (int i = 0; i < 27; i++) begin
      set_act(VEC[i].act);
      pull = VEC[i].pull;
      repeat (int'(VEC[i].n)) @(posedge clk);
      @(negedge clk);
      check(VEC[i].exp, int'(VEC[i].req));
    end

    // directed: asynchronous reset in the middle of the watch window (R9)
    set_act(4'h0);
    pull = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(4'b0010, 3);  // R3 now watching
    #(CLK_PERIOD / 4);
    rst_n = 1'b0;
    #1;
    check(4'b1010, 9);  // R9 takes effect without a clock edge
    @(negedge clk);
    rst_n = 1'b1;
    set_act(4'h0);
    // R9: two clocks for release, then 29 idle clocks until the release drive
    repeat (2 + 28) @(posedge clk);
    @(negedge clk);
    check(4'b1010, 9);  // R9 counters cleared by reset
    @(posedge clk);
    @(negedge clk);
    check(4'b1110, 2);  // R2

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule